// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that gives a host processor access to a bank of 8-bit configuration registers. SCL and SDA are sampled in the system clock through two-flop synchronizers. SDA is driven open-drain: the block only ever pulls the line low. The register bank and a one-cycle write strobe per register go to the rest of the chip.

A transfer begins with a device byte: a 7-bit address and a direction bit. The upper six address bits are a parameter, and bit 0 comes from the `addr_sel` pin. In a write, the first byte after the device byte loads a subaddress pointer. Each further byte is written to the register the pointer selects, and the pointer then advances. A read returns the register at the pointer and advances it. The pointer keeps its value from one transfer to the next, so the usual read is a write that carries only the subaddress, followed by a read. Subaddresses that do not exist are refused. Running past the top of the bank is handled differently for reads and for writes.

The protocol engine is a state machine with nine states:
- `ST_IDLE`: waits for a START.
- `ST_DEVADDR`: shifts in the device byte.
- `ST_ACK_DEV`: acknowledges the device byte.
- `ST_SUBADDR`: shifts in the subaddress.
- `ST_ACK_SUB`: acknowledges the subaddress.
- `ST_WR_DATA`: shifts in a write byte.
- `ST_ACK_WR`: acknowledges a write byte.
- `ST_TX_BYTE`: shifts a read byte out.
- `ST_TX_ACK`: samples the acknowledge from the master.

Transitions happen on a detected SCL falling edge once a byte is complete:
- `ST_DEVADDR` goes to `ST_ACK_DEV` on an address match, and to `ST_IDLE` otherwise.
- `ST_ACK_DEV` goes to `ST_TX_BYTE` for a read, and to `ST_SUBADDR` for a write.
- `ST_SUBADDR` goes to `ST_ACK_SUB` when the subaddress is valid, and to `ST_IDLE` otherwise.
- `ST_ACK_SUB` goes to `ST_WR_DATA`.
- `ST_WR_DATA` goes to `ST_ACK_WR` when the pointer is in range, and to `ST_IDLE` on overrun.
- `ST_ACK_WR` goes back to `ST_WR_DATA`.
- `ST_TX_BYTE` goes to `ST_TX_ACK`.
- `ST_TX_ACK` goes to `ST_TX_BYTE` when the master acknowledges, and to `ST_IDLE` when it does not.

Two bus conditions override all of these. A START from any state goes to `ST_DEVADDR`, and a STOP from any state goes to `ST_IDLE`.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The device byte is received MSB first. Bits 7..2 must equal `DEV_ADDR_HI`, bit 1 must equal `addr_sel` and bit 0 is the direction (1 = read, 0 = write). On a match the slave pulls SDA low during the ninth clock. On a mismatch it never drives SDA until the next START.
- R2: In a write, the byte after the device byte is the subaddress. It is valid only when bits 7:6 are zero and bits 5:0 are at most `HIGHEST_SUB`. A valid subaddress is acknowledged and loaded into the pointer. An invalid one is not acknowledged, leaves the pointer unchanged and returns the slave to idle.
- R3: Each write data byte goes to the register at the pointer. The byte is acknowledged, `wr_stb` for that register is high for exactly one cycle, the register takes the new value on the next cycle, and the pointer advances by one.
- R4: When a write byte arrives after the register at `HIGHEST_SUB` has been written, the byte is discarded and not acknowledged, no strobe occurs, and the slave returns to idle.
- R5: A read sends the register at the pointer, MSB first, and advances the pointer after each byte. When the master acknowledges, the next byte follows.
- R6: In a read, once the pointer is at `HIGHEST_SUB` (or past it), every further byte repeats the register at `HIGHEST_SUB`. A NACK from the master ends the read and releases SDA.
- R7: A START at any point abandons the current transfer and begins a new device byte. A STOP at any point returns the slave to idle. A partly received byte is dropped with no strobe and no pointer change.
- R8: After reset the registers hold these values:
  - registers 0..3: 0x16, 0x7C, 0xF0, 0x21, which is 0x21F07C16 with the least significant byte in register 0;
  - register 4: 0x10;
  - every other register: 0x00.
- R9: A subaddress up to `HIGHEST_SUB` whose bit in `IMPL_MASK` is clear is acknowledged, reads as 0x00, and ignores writes with no strobe. With the default parameters, registers 9 and 10 are of this kind.
- R10: The pointer keeps its value across STOP and START, so a read with no subaddress byte continues from where the last transfer left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| addr_sel | input | 1 | Supplies bit 0 of the 7-bit device address |
| sda_low | output | 1 | 1 = pull SDA low; 0 = release the line |
| regs_out | output | NREG*8 | Register bank; register i occupies bits 8*i+7..8*i |
| wr_stb | output | NREG | One-cycle write strobe per register |

## Verification
Two functions can meet in the same cycle: a START that cuts into a write byte, and the register write strobe that the next SCL fall of that byte would have raised. The bench shifts four bits of a data byte, issues a repeated START at once, and then reads the register back. It requires no strobe, an unchanged register and a pointer left where the subaddress put it. The reference model checks the whole bank on every clock. This also catches a stray write caused by a STOP that lands in the middle of a device byte.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_ACK_DEV,
        ST_SUBADDR,
        ST_ACK_SUB,
        ST_WR_DATA,
        ST_ACK_WR,
        ST_TX_BYTE,
        ST_TX_ACK
    } bus_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'h15,
    parameter int         HIGHEST_SUB = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  line_ev_t   ev,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic [5:0] rd_addr,
    output logic       wr_en,
    output logic [5:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_low,
    output bus_state_e cur_state,
    output logic [6:0] cur_ptr
);

    localparam logic [6:0] HI7 = 7'(HIGHEST_SUB);

    bus_state_e state, nstate;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [3:0] bitcnt;
    logic [6:0] ptr;
    logic       rw;
    logic       mack;

    logic byte_full;
    logic addr_hit;
    logic sub_ok;
    logic ptr_over;
    logic counting;

    assign byte_full = (bitcnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == {DEV_ADDR_HI, addr_sel});
    assign sub_ok    = (shreg[7:6] == 2'b00) && ({1'b0, shreg[5:0]} <= HI7);
    assign ptr_over  = (ptr > HI7);
    assign rd_addr   = ptr_over ? HI7[5:0] : ptr[5:0];
    assign counting  = (state == ST_DEVADDR) || (state == ST_SUBADDR) ||
                       (state == ST_WR_DATA) || (state == ST_TX_BYTE);
    assign cur_state = state;
    assign cur_ptr   = ptr;

    // next-state decode
    always_comb begin
        nstate = state;
        if (ev.start) begin
            nstate = ST_DEVADDR;
        end else if (ev.stop) begin
            nstate = ST_IDLE;
        end else if (ev.scl_fall) begin
            unique case (state)
                ST_IDLE:    nstate = ST_IDLE;
                ST_DEVADDR: if (byte_full) nstate = addr_hit ? ST_ACK_DEV : ST_IDLE;
                ST_ACK_DEV: nstate = rw ? ST_TX_BYTE : ST_SUBADDR;
                ST_SUBADDR: if (byte_full) nstate = sub_ok ? ST_ACK_SUB : ST_IDLE;
                ST_ACK_SUB: nstate = ST_WR_DATA;
                ST_WR_DATA: if (byte_full) nstate = ptr_over ? ST_IDLE : ST_ACK_WR;
                ST_ACK_WR:  nstate = ST_WR_DATA;
                ST_TX_BYTE: if (byte_full) nstate = ST_TX_ACK;
                ST_TX_ACK:  nstate = mack ? ST_TX_BYTE : ST_IDLE;
                default:    nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            txsh    <= '1;
            bitcnt  <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start || ev.stop) begin
                bitcnt <= '0;
                txsh   <= '1;
            end else if (ev.scl_rise) begin
                if (counting) begin
                    shreg <= {shreg[6:0], ev.sda};
                    if (!byte_full) bitcnt <= bitcnt + 4'd1;
                end
                if (state == ST_TX_ACK) mack <= ~ev.sda;
            end else if (ev.scl_fall) begin
                unique case (state)
                    ST_DEVADDR: if (byte_full) begin
                        bitcnt <= '0;
                        rw     <= shreg[0];
                    end
                    ST_ACK_DEV: begin
                        bitcnt <= '0;
                        if (rw) txsh <= rd_data;
                    end
                    ST_SUBADDR: if (byte_full) begin
                        bitcnt <= '0;
                        if (sub_ok) ptr <= {1'b0, shreg[5:0]};
                    end
                    ST_WR_DATA: if (byte_full) begin
                        bitcnt <= '0;
                        if (!ptr_over) begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr[5:0];
                            wr_data <= shreg;
                            ptr     <= ptr + 7'd1;
                        end
                    end
                    ST_TX_BYTE: begin
                        if (byte_full) begin
                            bitcnt <= '0;
                            txsh   <= '1;
                            ptr    <= (ptr >= HI7) ? HI7 : ptr + 7'd1;
                        end else begin
                            txsh <= {txsh[6:0], 1'b1};
                        end
                    end
                    ST_TX_ACK: if (mack) txsh <= rd_data;
                    default: ;
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_ACK_DEV, ST_ACK_SUB, ST_ACK_WR: sda_low = 1'b1;
            ST_TX_BYTE:                        sda_low = ~txsh[7];
            default:                           sda_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int          NREG       = 13,
    parameter logic [63:0] IMPL_MASK  = 64'h19FF,
    parameter logic [31:0] SUBCAR_RST = 32'h21F07C16,
    parameter int          PED_IDX    = 4,
    parameter int          PED_BIT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [5:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_out,
    output logic [NREG-1:0]   wr_stb
);

    function automatic logic [7:0] rst_val(input int idx);
        if (idx < 4)        return SUBCAR_RST[idx*8 +: 8];
        if (idx == PED_IDX) return 8'(1 << PED_BIT);
        return 8'h00;
    endfunction

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (IMPL_MASK[i]) begin : g_impl
            localparam logic [7:0] RV = rst_val(i);
            logic [7:0] q;
            assign wr_stb[i] = wr_en && (wr_addr == 6'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         q <= RV;
                else if (wr_stb[i]) q <= wr_data;
            end
            assign regs_out[i*8 +: 8] = q;
        end else begin : g_hole
            assign wr_stb[i]          = 1'b0;
            assign regs_out[i*8 +: 8] = 8'h00;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == 6'(i)) rd_data = regs_out[i*8 +: 8];
        end
    end

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter logic [5:0]  DEV_ADDR_HI = 6'h15,
    parameter int          HIGHEST_SUB = 12,
    parameter logic [63:0] IMPL_MASK   = 64'h19FF,
    parameter logic [31:0] SUBCAR_RST  = 32'h21F07C16,
    parameter int          PED_IDX     = 4,
    parameter int          PED_BIT     = 4,
    localparam int         NREG        = HIGHEST_SUB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    output logic              sda_low,
    output logic [NREG*8-1:0] regs_out,
    output logic [NREG-1:0]   wr_stb
);

    line_ev_t   line_ev;
    bus_state_e cur_state;
    logic [6:0] cur_ptr;
    logic [5:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [5:0] wr_addr;
    logic [7:0] wr_data;

    i2c_line_sync #(.SYNC_STAGES(2)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (line_ev)
    );

    i2c_byte_fsm #(
        .DEV_ADDR_HI (DEV_ADDR_HI),
        .HIGHEST_SUB (HIGHEST_SUB)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (line_ev),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_low   (sda_low),
        .cur_state (cur_state),
        .cur_ptr   (cur_ptr)
    );

    i2c_reg_bank #(
        .NREG       (NREG),
        .IMPL_MASK  (IMPL_MASK),
        .SUBCAR_RST (SUBCAR_RST),
        .PED_IDX    (PED_IDX),
        .PED_BIT    (PED_BIT)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .regs_out (regs_out),
        .wr_stb   (wr_stb)
    );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
    import i2c_cfg_pkg::*;
#(
    parameter int HIGHEST_SUB = 12,
    parameter int NREG        = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic              ev_stop,
    input bus_state_e        state,
    input logic [NREG-1:0]   wr_stb,
    input logic [NREG*8-1:0] regs_out,
    input logic [6:0]        ptr
);

    a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> state == ST_DEVADDR);

    a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> state == ST_IDLE);

    a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    a_r3_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_out) |-> $past(|wr_stb));

    a_r3_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> state == ST_ACK_WR);

    a_r4_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= 7'(HIGHEST_SUB + 1));

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
    .HIGHEST_SUB (HIGHEST_SUB),
    .NREG        (NREG)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_start (line_ev.start),
    .ev_stop  (line_ev.stop),
    .state    (cur_state),
    .wr_stb   (wr_stb),
    .regs_out (regs_out),
    .ptr      (cur_ptr)
);

// File: tb/i2c_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_cfg_slave_tb_top;

    localparam int          HI   = 12;
    localparam int          NREG = HI + 1;
    localparam logic [5:0]  DEVA = 6'h15;
    localparam logic [12:0] IMPL = 13'h19FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sel = 1'b0;
    logic sda_low;
    logic sda_line;
    logic [NREG*8-1:0] regs_out;
    logic [NREG-1:0]   wr_stb;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_low;

    i2c_cfg_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .addr_sel (sel),
        .sda_low  (sda_low),
        .regs_out (regs_out),
        .wr_stb   (wr_stb)
    );

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit hold = 1'b1;

    logic [7:0] m_reg [NREG];
    int         m_stb [NREG];
    int         stb_cnt [NREG];
    int         m_ptr = 0;

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the whole bank against the model (R3, R8, R9).
    always @(negedge clk) begin
        if (rst_n && !hold && !done) begin
            logic [NREG*8-1:0] e;
            for (int i = 0; i < NREG; i++) e[i*8 +: 8] = m_reg[i];
            compared++;
            if (regs_out !== e) begin
                mismatched++;
                $display("FAIL R3/R8 bank: got %h expected %h", regs_out, e);
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n) for (int i = 0; i < NREG; i++) if (wr_stb[i]) stb_cnt[i]++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: got %0d expected %0d cycles", cycles, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(4);
        scl_m = 1'b1; w(4);
        sda_m = 1'b0; w(4);
        scl_m = 1'b0; w(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(4);
        scl_m = 1'b1; w(4);
        sda_m = 1'b1; w(4);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; w(4);
        scl_m = 1'b1; w(8);
        scl_m = 1'b0; w(4);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; w(4);
        scl_m = 1'b1; w(4);
        b = sda_line; w(4);
        scl_m = 1'b0; w(4);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    function automatic bit sub_valid(input logic [7:0] s);
        return (s[7:6] == 2'b00) && (int'(s[5:0]) <= HI);
    endfunction

    task automatic wr_txn(input logic [7:0] sub, input int n, input logic [7:0] d [4]);
        logic ack;
        bus_start();
        send_byte({DEVA, sel, 1'b0}, ack);
        check("R1 device ack (write)", ack, 1);
        send_byte(sub, ack);
        check("R2 subaddress ack", ack, sub_valid(sub));
        if (sub_valid(sub)) begin
            m_ptr = sub[5:0];
            for (int k = 0; k < n; k++) begin
                bit exp_ack;
                hold = 1'b1;
                send_byte(d[k], ack);
                exp_ack = (m_ptr <= HI);
                if (exp_ack) begin
                    if (IMPL[m_ptr]) begin
                        m_reg[m_ptr] = d[k];
                        m_stb[m_ptr]++;
                    end
                    m_ptr++;
                end
                check(exp_ack ? "R3 data ack" : "R4 overrun nack", ack, exp_ack);
                hold = 1'b0;
                if (!exp_ack) break;
            end
        end
        bus_stop();
    endtask

    task automatic rd_bytes(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            int idx;
            idx = (m_ptr > HI) ? HI : m_ptr;
            recv_byte(d, k < n - 1);
            check(tag, d, m_reg[idx]);
            m_ptr = (m_ptr >= HI) ? HI : m_ptr + 1;
        end
    endtask

    task automatic rd_txn(input int n, input string tag);
        logic ack;
        bus_start();
        send_byte({DEVA, sel, 1'b1}, ack);
        check("R1 device ack (read)", ack, 1);
        rd_bytes(n, tag);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d [4];
        for (int i = 0; i < NREG; i++) begin
            m_reg[i] = 8'h00;
            m_stb[i] = 0;
            stb_cnt[i] = 0;
        end
        // R8 reset values
        m_reg[0] = 8'h16; m_reg[1] = 8'h7C; m_reg[2] = 8'hF0; m_reg[3] = 8'h21;
        m_reg[4] = 8'h10;
        w(5);
        rst_n = 1'b1;
        w(5);
        hold = 1'b0;
        check("R8 reg0", regs_out[7:0], 8'h16);
        check("R8 reg3", regs_out[31:24], 8'h21);
        check("R8 reg4", regs_out[39:32], 8'h10);
        check("R1 released after reset", sda_low, 0);

        // R1 address mismatch: no ack, no drive
        bus_start();
        send_byte({DEVA, ~sel, 1'b0}, ack);
        check("R1 mismatch nack", ack, 0);
        send_byte(8'h05, ack);
        check("R1 mismatch stays quiet", ack, 0);
        bus_stop();

        // R3 auto-increment write, R10 + R5 read back
        d = '{8'hAA, 8'hBB, 8'h00, 8'h00};
        wr_txn(8'h05, 2, d);
        wr_txn(8'h05, 0, d);
        rd_txn(3, "R5 read sequence");

        // R2 invalid subaddresses
        wr_txn(8'h45, 1, d);
        wr_txn(8'h0D, 1, d);
        rd_txn(1, "R2 pointer unchanged after nack");

        // R4 write overrun
        d = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_txn(8'h0B, 3, d);
        check("R4 released after overrun", sda_low, 0);
        rd_txn(2, "R6 read after overrun clamps");

        // R6 read past highest
        wr_txn(8'h0B, 0, d);
        rd_txn(4, "R6 repeat highest");
        check("R6 released after master nack", sda_low, 0);

        // R9 hole
        d = '{8'h77, 8'h00, 8'h00, 8'h00};
        wr_txn(8'h09, 1, d);
        wr_txn(8'h09, 0, d);
        rd_txn(2, "R9 hole reads zero");

        // R10 pointer persists over stop
        wr_txn(8'h02, 0, d);
        rd_txn(1, "R10 pointer kept");

        // R7 START during a write byte: partial byte dropped
        bus_start();
        send_byte({DEVA, sel, 1'b0}, ack);
        send_byte(8'h00, ack);
        m_ptr = 0;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte({DEVA, sel, 1'b1}, ack);
        check("R7 restart device ack", ack, 1);
        rd_bytes(1, "R7 partial byte dropped");
        bus_stop();

        // R7 STOP inside a device byte
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_stop();
        check("R7 idle after stop", sda_low, 0);

        // R1 other address-select value
        sel = 1'b1;
        d = '{8'h5A, 8'h00, 8'h00, 8'h00};
        wr_txn(8'h0C, 1, d);
        rd_txn(1, "R1 addr_sel=1 access");

        w(20);
        for (int i = 0; i < NREG; i++)
            check(IMPL[i] ? "R3 strobe count" : "R9 hole strobe count", stb_cnt[i], m_stb[i]);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule